// File: doc/BRIEF.md
# PCM Port Control and Clock-Crossing Handshake

This block is the control and status word of a PCM audio port. Software reaches it over a simple register write/read path clocked by the system clock. The block keeps the port's enable, run and wake settings in the system domain and carries them into a separate PCM bit-clock domain. It turns FIFO clear requests into single-cycle strobes in the PCM domain. It also reports FIFO status flags and two sticky error flags. The serial framing engine and the FIFO storage are not part of the block. They appear only as status inputs and as strobe and level outputs.

A sync bit lets software confirm that the PCM clock is running. The value written to it goes into the PCM domain through a synchronizer and comes back through a second synchronizer. Only then does it appear at bit 24 of the read data. Software toggles the bit and waits for the read-back to follow. When it does, at least two PCM clock edges have passed since the write, so any clear strobe issued together with it has reached the FIFO logic. If the PCM clock is stopped, the read-back never changes.

Writes carry a per-bit enable mask. Software can therefore change one run bit, one clear strobe or one error flag without disturbing the others.

Top module: `pcm_ctl_sync`

## Requirements
- R1: After reset, `rdata` holds only the status flag bits copied from `fifo_flags`, and all PCM-domain outputs (`pcm_en`, `pcm_rx_on`, `pcm_tx_on`, `pcm_tx_clr`, `pcm_rx_clr`, `pcm_awake`) are 0.
- R2: A write with `wr_en` high updates each writable bit whose `wmask` bit is 1 and leaves every other bit unchanged. The result is visible in `rdata` one system clock later. The writable bits are: bit 0 port enable, bit 1 receive run, bit 2 transmit run, bits 6:5 transmit threshold, bits 8:7 receive threshold, bit 9 DMA request enable, bit 23 receive sign-extend, bit 25 wake. The thresholds, DMA enable and sign-extend also drive `tx_thr`, `rx_thr`, `dma_en` and `rx_sext`.
- R3: `pcm_en`, `pcm_rx_on` and `pcm_tx_on` follow bits 0, 1 and 2 after a two-flop synchronizer in the PCM domain. Switching one direction off leaves the other direction's run output unchanged.
- R4: Writing 1 to bit 3 (transmit clear) gives exactly one `pcm_tx_clr` pulse, one PCM cycle wide, and no `pcm_rx_clr` pulse. Bit 4 (receive clear) does the same on `pcm_rx_clr` only. Both clear bits always read back as 0.
- R5: The value written to bit 24 (sync) appears at `rdata[24]` only after at least two PCM rising edges. While the PCM clock is stopped, `rdata[24]` does not change.
- R6: After bit 25 is set, `pcm_awake` goes high no sooner than 4 PCM rising edges later. It returns low once the cleared bit 25 has been synchronized into the PCM domain.
- R7: Each `fifo_flags` bit appears at a fixed read position: flag 0 at bit 13, flag 1 at bit 14, and flags 2 to 7 at bits 17 to 22.
- R8: A pulse on `tx_err_evt` sets bit 15 and a pulse on `rx_err_evt` sets bit 16. Each flag holds until a write with mask and data both 1 at its own position clears it. If an event and a clear arrive in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System-domain reset, active low |
| pcm_clk | input | 1 | PCM bit clock |
| pcm_rst_n | input | 1 | PCM-domain reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wmask | input | 32 | Per-bit write enable |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Control/status read-back |
| fifo_flags | input | 8 | FIFO status flags (see R7) |
| tx_err_evt | input | 1 | Transmit underrun event pulse |
| rx_err_evt | input | 1 | Receive overrun event pulse |
| tx_thr | output | 2 | Transmit FIFO threshold setting |
| rx_thr | output | 2 | Receive FIFO threshold setting |
| dma_en | output | 1 | DMA request enable |
| rx_sext | output | 1 | Receive sign-extension enable |
| pcm_en | output | 1 | Port enable in the PCM domain |
| pcm_rx_on | output | 1 | Receive run in the PCM domain |
| pcm_tx_on | output | 1 | Transmit run in the PCM domain |
| pcm_tx_clr | output | 1 | Transmit FIFO clear strobe (PCM domain) |
| pcm_rx_clr | output | 1 | Receive FIFO clear strobe (PCM domain) |
| pcm_awake | output | 1 | Wake complete, standby released (PCM domain) |

## Verification
The hardest case to reach from the ports is a sync toggle issued while the PCM clock is not running. The read-back must then stay frozen, and it must move only once PCM edges resume. The bench gates its own PCM clock while the clock is low and issues the sync write into that silence. It holds for a long run of system cycles and checks that bit 24 does not move. It then restarts the clock and counts PCM rising edges until the echo arrives. The wake and clear paths are measured the same way: the bench counts PCM edges and strobe pulses against write times.

// File: rtl/pcm_ctl_pkg.sv
`timescale 1ns/1ps
package pcm_ctl_pkg;
  localparam int REG_W    = 32;
  localparam int THR_W    = 2;
  localparam int FLAG_W   = 8;
  // control positions
  localparam int B_EN     = 0;
  localparam int B_RXON   = 1;
  localparam int B_TXON   = 2;
  localparam int B_TXCLR  = 3;
  localparam int B_RXCLR  = 4;
  localparam int B_TXTHR  = 5;
  localparam int B_RXTHR  = B_TXTHR + THR_W;
  localparam int B_DMA    = B_RXTHR + THR_W;
  // status positions
  localparam int B_TXSYNC = 13;
  localparam int B_RXSYNC = 14;
  localparam int B_TXERR  = 15;
  localparam int B_RXERR  = 16;
  localparam int B_FLAGHI = 17;
  localparam int B_SEXT   = 23;
  localparam int B_SYNC   = 24;
  localparam int B_AWAKE  = 25;

  // Sticky flag: a new event wins over a same-cycle clear.
  function automatic logic sticky_next(logic cur, logic set_ev, logic clr_req);
    return set_ev | (cur & ~clr_req);
  endfunction

  // Place the FIFO flags into their read positions.
  function automatic logic [REG_W-1:0] place_flags(logic [FLAG_W-1:0] f);
    logic [REG_W-1:0] w;
    w = '0;
    w[B_TXSYNC] = f[0];
    w[B_RXSYNC] = f[1];
    for (int i = 2; i < FLAG_W; i++) w[B_FLAGHI + i - 2] = f[i];
    return w;
  endfunction

  // Masked update of one bit.
  function automatic logic pick_bit(logic cur, logic sel, logic d);
    return sel ? d : cur;
  endfunction
endpackage

// File: rtl/pcm_bit_sync.sv
`timescale 1ns/1ps
module pcm_bit_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pcm_pulse_xfer.sv
`timescale 1ns/1ps
module pcm_pulse_xfer #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_pulse,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);
  logic src_tgl;
  logic dst_tgl_s;
  logic dst_tgl_d;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n)     src_tgl <= 1'b0;
    else if (src_pulse) src_tgl <= ~src_tgl;
  end

  pcm_bit_sync #(.WIDTH(1), .STAGES(STAGES)) u_tgl_sync (
    .clk(dst_clk), .rst_n(dst_rst_n), .d(src_tgl), .q(dst_tgl_s)
  );

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) dst_tgl_d <= 1'b0;
    else            dst_tgl_d <= dst_tgl_s;
  end

  assign dst_pulse = dst_tgl_s ^ dst_tgl_d;

  AST_CLR_TOGGLES: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_pulse |=> (src_tgl != $past(src_tgl))); // R4
endmodule

// File: rtl/pcm_wake_timer.sv
`timescale 1ns/1ps
module pcm_wake_timer #(
  parameter int STAGES = 2,
  parameter int CYCLES = 4
) (
  input  logic pcm_clk,
  input  logic pcm_rst_n,
  input  logic wake_req,
  output logic pcm_awake
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic             req_s;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_full;

  pcm_bit_sync #(.WIDTH(1), .STAGES(STAGES)) u_req_sync (
    .clk(pcm_clk), .rst_n(pcm_rst_n), .d(wake_req), .q(req_s)
  );

  assign cnt_full = (cnt_q == CNT_W'(CYCLES));

  always_ff @(posedge pcm_clk or negedge pcm_rst_n) begin
    if (!pcm_rst_n)     cnt_q <= '0;
    else if (!req_s)    cnt_q <= '0;
    else if (!cnt_full) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign pcm_awake = cnt_full;

  AST_WAKE_DROPS: assert property (@(posedge pcm_clk) disable iff (!pcm_rst_n)
    !req_s |=> !pcm_awake); // R6
  AST_WAKE_NEEDS_REQ: assert property (@(posedge pcm_clk) disable iff (!pcm_rst_n)
    $rose(pcm_awake) |-> $past(req_s)); // R6
endmodule

// File: rtl/pcm_ctl_regs.sv
`timescale 1ns/1ps
module pcm_ctl_regs
  import pcm_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wmask,
  input  logic [REG_W-1:0]  wdata,
  input  logic [FLAG_W-1:0] fifo_flags,
  input  logic              tx_err_evt,
  input  logic              rx_err_evt,
  input  logic              sync_echo,
  output logic [REG_W-1:0]  rdata,
  output logic              en_q,
  output logic              rx_on_q,
  output logic              tx_on_q,
  output logic [THR_W-1:0]  tx_thr_q,
  output logic [THR_W-1:0]  rx_thr_q,
  output logic              dma_q,
  output logic              sext_q,
  output logic              sync_req_q,
  output logic              awake_q,
  output logic              tx_clr_req,
  output logic              rx_clr_req
);
  logic [REG_W-1:0] wsel;
  logic             tx_err_q;
  logic             rx_err_q;
  logic             unused_wbits;

  assign wsel         = wr_en ? wmask : '0;
  assign unused_wbits = ^{wsel, wdata};

  assign tx_clr_req = wsel[B_TXCLR] & wdata[B_TXCLR];
  assign rx_clr_req = wsel[B_RXCLR] & wdata[B_RXCLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      rx_on_q    <= 1'b0;
      tx_on_q    <= 1'b0;
      tx_thr_q   <= '0;
      rx_thr_q   <= '0;
      dma_q      <= 1'b0;
      sext_q     <= 1'b0;
      sync_req_q <= 1'b0;
      awake_q    <= 1'b0;
      tx_err_q   <= 1'b0;
      rx_err_q   <= 1'b0;
    end else begin
      en_q       <= pick_bit(en_q,       wsel[B_EN],    wdata[B_EN]);
      rx_on_q    <= pick_bit(rx_on_q,    wsel[B_RXON],  wdata[B_RXON]);
      tx_on_q    <= pick_bit(tx_on_q,    wsel[B_TXON],  wdata[B_TXON]);
      dma_q      <= pick_bit(dma_q,      wsel[B_DMA],   wdata[B_DMA]);
      sext_q     <= pick_bit(sext_q,     wsel[B_SEXT],  wdata[B_SEXT]);
      sync_req_q <= pick_bit(sync_req_q, wsel[B_SYNC],  wdata[B_SYNC]);
      awake_q    <= pick_bit(awake_q,    wsel[B_AWAKE], wdata[B_AWAKE]);
      for (int b = 0; b < THR_W; b++) begin
        tx_thr_q[b] <= pick_bit(tx_thr_q[b], wsel[B_TXTHR+b], wdata[B_TXTHR+b]);
        rx_thr_q[b] <= pick_bit(rx_thr_q[b], wsel[B_RXTHR+b], wdata[B_RXTHR+b]);
      end
      tx_err_q <= sticky_next(tx_err_q, tx_err_evt, wsel[B_TXERR] & wdata[B_TXERR]);
      rx_err_q <= sticky_next(rx_err_q, rx_err_evt, wsel[B_RXERR] & wdata[B_RXERR]);
    end
  end

  always_comb begin
    rdata                      = place_flags(fifo_flags);
    rdata[B_EN]                = en_q;
    rdata[B_RXON]              = rx_on_q;
    rdata[B_TXON]              = tx_on_q;
    rdata[B_TXTHR +: THR_W]    = tx_thr_q;
    rdata[B_RXTHR +: THR_W]    = rx_thr_q;
    rdata[B_DMA]               = dma_q;
    rdata[B_TXERR]             = tx_err_q;
    rdata[B_RXERR]             = rx_err_q;
    rdata[B_SEXT]              = sext_q;
    rdata[B_SYNC]              = sync_echo;
    rdata[B_AWAKE]             = awake_q;
  end

  AST_TXERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err_q && !(wr_en && wmask[B_TXERR] && wdata[B_TXERR]) |=> tx_err_q); // R8
  AST_RXERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_evt |=> rx_err_q); // R8
  AST_RXRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wmask[B_RXON]) |=> $stable(rx_on_q)); // R3
  AST_TXRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wmask[B_TXON]) |=> $stable(tx_on_q)); // R3
endmodule

// File: rtl/pcm_ctl_sync.sv
`timescale 1ns/1ps
module pcm_ctl_sync
  import pcm_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pcm_clk,
  input  logic              pcm_rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wmask,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic [FLAG_W-1:0] fifo_flags,
  input  logic              tx_err_evt,
  input  logic              rx_err_evt,
  output logic [THR_W-1:0]  tx_thr,
  output logic [THR_W-1:0]  rx_thr,
  output logic              dma_en,
  output logic              rx_sext,
  output logic              pcm_en,
  output logic              pcm_rx_on,
  output logic              pcm_tx_on,
  output logic              pcm_tx_clr,
  output logic              pcm_rx_clr,
  output logic              pcm_awake
);
  localparam int N_CLR = 2;

  logic             en_q, rx_on_q, tx_on_q;
  logic             sync_req, sync_pcm, sync_echo;
  logic             awake_req;
  logic [N_CLR-1:0] clr_req;
  logic [N_CLR-1:0] clr_pcm;

  pcm_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wmask(wmask), .wdata(wdata),
    .fifo_flags(fifo_flags), .tx_err_evt(tx_err_evt), .rx_err_evt(rx_err_evt),
    .sync_echo(sync_echo), .rdata(rdata),
    .en_q(en_q), .rx_on_q(rx_on_q), .tx_on_q(tx_on_q),
    .tx_thr_q(tx_thr), .rx_thr_q(rx_thr), .dma_q(dma_en), .sext_q(rx_sext),
    .sync_req_q(sync_req), .awake_q(awake_req),
    .tx_clr_req(clr_req[0]), .rx_clr_req(clr_req[1])
  );

  // Run levels into the PCM domain; each bit is independent.
  pcm_bit_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_run_sync (
    .clk(pcm_clk), .rst_n(pcm_rst_n),
    .d({tx_on_q, rx_on_q, en_q}),
    .q({pcm_tx_on, pcm_rx_on, pcm_en})
  );

  // Clear strobes, one toggle transfer per FIFO.
  for (genvar g = 0; g < N_CLR; g++) begin : g_clr
    pcm_pulse_xfer #(.STAGES(SYNC_STAGES)) u_xfer (
      .src_clk(clk), .src_rst_n(rst_n), .src_pulse(clr_req[g]),
      .dst_clk(pcm_clk), .dst_rst_n(pcm_rst_n), .dst_pulse(clr_pcm[g])
    );
  end
  assign pcm_tx_clr = clr_pcm[0];
  assign pcm_rx_clr = clr_pcm[1];

  // Sync echo: forward into the PCM domain, then back out.
  pcm_bit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_sync_fwd (
    .clk(pcm_clk), .rst_n(pcm_rst_n), .d(sync_req), .q(sync_pcm)
  );
  pcm_bit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_sync_back (
    .clk(clk), .rst_n(rst_n), .d(sync_pcm), .q(sync_echo)
  );

  pcm_wake_timer #(.STAGES(SYNC_STAGES), .CYCLES(WAKE_CYCLES)) u_wake (
    .pcm_clk(pcm_clk), .pcm_rst_n(pcm_rst_n), .wake_req(awake_req), .pcm_awake(pcm_awake)
  );

  AST_ECHO_TOWARD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sync_echo) |-> (sync_echo == sync_req)); // R5
  AST_CLR_NEVER_BOTH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wmask[B_TXCLR] && wdata[B_TXCLR]) |=> (rdata[B_TXCLR] == 1'b0)); // R4
endmodule

// File: tb/pcm_ctl_sync_bench.sv
`timescale 1ns/100ps
module pcm_ctl_sync_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pcm_clk = 1'b0;
  logic        pcm_rst_n = 1'b0;
  logic        pcm_go = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wmask = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  fifo_flags = '0;
  logic        tx_err_evt = 1'b0;
  logic        rx_err_evt = 1'b0;
  logic [1:0]  tx_thr, rx_thr;
  logic        dma_en, rx_sext, pcm_en, pcm_rx_on, pcm_tx_on;
  logic        pcm_tx_clr, pcm_rx_clr, pcm_awake;

  int n_tests = 0;
  int n_fail  = 0;
  int pcm_edges = 0;
  int n_txclr = 0;
  int n_rxclr = 0;
  logic [31:0] model = '0;
  localparam logic [31:0] WRITABLE = 32'h0280_03E7;

  pcm_ctl_sync u_pcm_ctl_sync (
    .clk(clk), .rst_n(rst_n), .pcm_clk(pcm_clk), .pcm_rst_n(pcm_rst_n),
    .wr_en(wr_en), .wmask(wmask), .wdata(wdata), .rdata(rdata),
    .fifo_flags(fifo_flags), .tx_err_evt(tx_err_evt), .rx_err_evt(rx_err_evt),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .dma_en(dma_en), .rx_sext(rx_sext),
    .pcm_en(pcm_en), .pcm_rx_on(pcm_rx_on), .pcm_tx_on(pcm_tx_on),
    .pcm_tx_clr(pcm_tx_clr), .pcm_rx_clr(pcm_rx_clr), .pcm_awake(pcm_awake)
  );

  always #2 clk = ~clk;
  initial begin
    #1.5;
    forever begin
      #5;
      if (pcm_go) pcm_clk = ~pcm_clk;
    end
  end
  always @(posedge pcm_clk) pcm_edges++;
  always @(negedge pcm_clk) begin
    if (pcm_tx_clr) n_txclr++;
    if (pcm_rx_clr) n_rxclr++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] m, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wmask = m; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wmask = '0; wdata = '0;
    model = (model & ~(m & WRITABLE)) | (d & m & WRITABLE);
  endtask

  function automatic logic [31:0] flag_pos(input logic [7:0] f);
    return ({24'd0, f[1:0]} << 13) | ({24'd0, f[7:2]} << 17);
  endfunction

  task automatic pcm_wait(input int n);
    repeat (n) @(negedge pcm_clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int e0;
    int got;
    int t0, r0;
    repeat (3) @(negedge pcm_clk);
    @(negedge clk);
    rst_n = 1'b1; pcm_rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata after reset", rdata, 32'h0);
    chk("R1 pcm outputs after reset",
        {26'd0, pcm_en, pcm_rx_on, pcm_tx_on, pcm_tx_clr, pcm_rx_clr, pcm_awake}, 32'h0);

    // R7 exhaustive flag placement
    for (int f = 0; f < 256; f++) begin
      fifo_flags = f[7:0];
      #1;
      chk("R7 flag placement", rdata, flag_pos(f[7:0]));
    end
    fifo_flags = '0;

    // R2 masked write sweep (clears, errors and sync kept out of the mask)
    for (int i = 0; i < 512; i++) begin
      logic [31:0] m, d;
      d = i * 32'h9E37_79B1;
      m = ((i * 32'h85EB_CA6B) ^ (i << 7)) & ~32'h0101_8018;
      wr(m, d);
      chk("R2 masked write read-back", rdata, model);
      chk("R2 field outputs", {26'd0, rx_sext, dma_en, rx_thr, tx_thr},
          {26'd0, model[23], model[9], model[8:7], model[6:5]});
    end

    // R3 run levels and direction independence
    wr(32'h7, 32'h7);
    pcm_wait(4);
    chk("R3 all run outputs on", {29'd0, pcm_en, pcm_rx_on, pcm_tx_on}, 32'h7);
    wr(32'h4, 32'h0);
    pcm_wait(4);
    chk("R3 tx off keeps rx", {29'd0, pcm_en, pcm_rx_on, pcm_tx_on}, 32'h6);
    wr(32'h6, 32'h4);
    pcm_wait(4);
    chk("R3 rx off keeps tx", {29'd0, pcm_en, pcm_rx_on, pcm_tx_on}, 32'h5);

    // R4 clear strobes
    t0 = n_txclr; r0 = n_rxclr;
    wr(32'h8, 32'h8);
    chk("R4 tx clear reads 0", {31'd0, rdata[3]}, 32'h0);
    pcm_wait(5);
    chk("R4 one tx pulse", n_txclr - t0, 1);
    chk("R4 no rx pulse", n_rxclr - r0, 0);
    t0 = n_txclr; r0 = n_rxclr;
    wr(32'h10, 32'h10);
    chk("R4 rx clear reads 0", {31'd0, rdata[4]}, 32'h0);
    pcm_wait(5);
    chk("R4 one rx pulse", n_rxclr - r0, 1);
    chk("R4 tx untouched by rx clear", n_txclr - t0, 0);
    t0 = n_txclr; r0 = n_rxclr;
    wr(32'h18, 32'h08);
    pcm_wait(5);
    chk("R4 masked data 0 gives no rx pulse", n_rxclr - r0, 0);
    chk("R4 tx pulse with mixed data", n_txclr - t0, 1);

    // R5 sync echo with a stopped PCM clock
    @(negedge pcm_clk);
    pcm_go = 1'b0;
    e0 = pcm_edges;
    wr(32'h0100_0000, 32'h0100_0000);
    repeat (200) @(negedge clk);
    chk("R5 frozen while PCM clock stopped", {31'd0, rdata[24]}, 32'h0);
    pcm_go = 1'b1;
    got = 0;
    for (int k = 0; k < 200 && got == 0; k++) begin
      @(negedge clk);
      if (rdata[24]) got = 1;
    end
    chk("R5 echo arrives after restart", got, 1);
    chk("R5 at least two PCM edges", {31'd0, (pcm_edges - e0) >= 2}, 32'h1);
    e0 = pcm_edges;
    wr(32'h0100_0000, 32'h0);
    chk("R5 no immediate read-back", {31'd0, rdata[24]}, 32'h1);
    got = 0;
    for (int k = 0; k < 200 && got == 0; k++) begin
      @(negedge clk);
      if (!rdata[24]) got = 1;
    end
    chk("R5 echo returns to 0", got, 1);
    chk("R5 at least two PCM edges on return", {31'd0, (pcm_edges - e0) >= 2}, 32'h1);

    // R6 wake timing
    wr(32'h0200_0000, 32'h0);
    pcm_wait(8);
    chk("R6 asleep after clearing wake", {31'd0, pcm_awake}, 32'h0);
    e0 = pcm_edges;
    wr(32'h0200_0000, 32'h0200_0000);
    got = 0;
    for (int k = 0; k < 30 && got == 0; k++) begin
      @(negedge pcm_clk);
      if (pcm_awake) got = 1;
    end
    chk("R6 wake completes", got, 1);
    chk("R6 no sooner than 4 PCM edges", {31'd0, (pcm_edges - e0) >= 4}, 32'h1);
    wr(32'h0200_0000, 32'h0);
    pcm_wait(4);
    chk("R6 awake drops after release", {31'd0, pcm_awake}, 32'h0);

    // R8 sticky errors
    @(negedge clk); tx_err_evt = 1'b1;
    @(negedge clk); tx_err_evt = 1'b0;
    chk("R8 tx error set", {30'd0, rdata[16], rdata[15]}, 32'h1);
    wr(32'h0001_0000, 32'h0001_0000);
    chk("R8 rx clear leaves tx error", {30'd0, rdata[16], rdata[15]}, 32'h1);
    wr(32'h0000_8000, 32'h0);
    chk("R8 data 0 does not clear", {30'd0, rdata[16], rdata[15]}, 32'h1);
    wr(32'h0000_8000, 32'h0000_8000);
    chk("R8 write 1 clears tx error", {30'd0, rdata[16], rdata[15]}, 32'h0);
    @(negedge clk);
    rx_err_evt = 1'b1; wr_en = 1'b1; wmask = 32'h0001_0000; wdata = 32'h0001_0000;
    @(negedge clk);
    rx_err_evt = 1'b0; wr_en = 1'b0; wmask = '0; wdata = '0;
    chk("R8 event wins over clear", {30'd0, rdata[16], rdata[15]}, 32'h2);
    wr(32'h0001_0000, 32'h0001_0000);
    chk("R8 rx error cleared", {30'd0, rdata[16], rdata[15]}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule